// File: doc/BRIEF.md
# Dual-Rail Supply Supervisor with Fault Latch

This block is the digital supervisor for a switching regulator with two rails: a 3.3 V rail (index 0) and a 5 V rail (index 1). It runs on the converter oscillator clock. Its inputs are a master enable, a lockout-clear input, and three comparator flags per rail: in-regulation, overvoltage and undervoltage. From these it drives a system reset, an enable for each converter, and two commands to the synchronous rectifiers. The system reset is given as a pull-low enable for an open-drain pin, with an external pull-up supplying the high level.

The reset is released only after both rails have held in-regulation, with the lockout clear and the enable high, for a full oscillator-count delay. The default delay is 32,000 cycles. An overvoltage on either rail latches every low-side driver fully on. An undervoltage, once the per-rail blanking window after converter start has expired, latches the converters off and clamps their outputs low. Each fault stays latched until the master enable is taken low and then high again.

Every input passes through a two-stage synchronizer before the logic uses it.

Top module: `psup_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_pull_low_o` is 1, and `conv_en_o`, `ls_force_o` and `ls_clamp_o` are all 0.
- R2: With the enable and lockout-clear high and no fault latched, both bits of `conv_en_o` are 1. This holds 2 clock edges after the inputs change (synchronizer delay).
- R3: With enable, lockout-clear and both in-regulation flags held high from one clock, `rst_pull_low_o` stays 1 through edge RST_DLY+1 and drops to 0 at edge RST_DLY+2.
- R4: If either in-regulation flag drops, the reset delay count restarts from zero. If this happens after release, `rst_pull_low_o` returns to 1 three edges after the drop.
- R5: An overvoltage flag on either rail latches `ls_force_o`=1 three edges after it rises. While the fault is latched, `conv_en_o`=0 and `rst_pull_low_o`=1, and the latch persists after the flag clears.
- R6: An undervoltage flag is ignored until a rail's converter has been enabled for UV_BLANK cycles. During that window `conv_en_o` stays 3 and `ls_clamp_o` stays 0.
- R7: An undervoltage flag on either rail after blanking latches `ls_clamp_o`=1, `conv_en_o`=0 and `rst_pull_low_o`=1, and the latch persists after the flag clears.
- R8: `ls_force_o` and `ls_clamp_o` are never both 1. When overvoltage and undervoltage arrive together, or overvoltage arrives while undervoltage is latched, the result is `ls_force_o`=1 and `ls_clamp_o`=0.
- R9: A latched fault clears only when the enable goes low. With the enable low, both fault outputs are 0, `conv_en_o`=0 and `rst_pull_low_o`=1, and the reset and blanking counts restart.
- R10: While lockout-clear is low, `conv_en_o` is 0 and `rst_pull_low_o` stays 1 regardless of the in-regulation flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Master enable |
| lockout_clr_i | input | 1 | High once input undervoltage lockout has cleared |
| rail_good_i | input | 2 | In-regulation flags, bit0 = 3.3 V, bit1 = 5 V |
| rail_ov_i | input | 2 | Overvoltage flags per rail |
| rail_uv_i | input | 2 | Undervoltage flags per rail |
| rst_pull_low_o | output | 1 | 1 = pull the system reset pin low (reset asserted) |
| conv_en_o | output | 2 | Per-rail converter enable |
| ls_force_o | output | 1 | All low-side rectifiers forced fully on (overvoltage latch) |
| ls_clamp_o | output | 1 | Converters off, outputs clamped low (undervoltage latch) |

## Verification
The blanking boundary is the hardest case to reach from the ports, because nothing at the outputs shows whether undervoltage checking is armed. The bench therefore holds the undervoltage flag high from the moment the enable rises. It then samples the cycle just before and the cycle just after the computed arming edge, which exposes the boundary as the edge at which the clamp latches. The fault priority cases are reached the same way: the bench stacks overvoltage on a latched undervoltage, and it raises both flags in one cycle after arming. Short counter parameters keep each scenario to a few hundred cycles.

// File: rtl/psup_pkg.sv
package psup_pkg;
    localparam int unsigned NRAIL = 2;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UV   = 2'd1,
        FLT_OV   = 2'd2
    } fault_e;
endpackage

// File: rtl/psup_sync.sv
module psup_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/psup_blank_timer.sv
module psup_blank_timer #(
    parameter int unsigned LIMIT = 6144
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)          cnt_d = '0;
        else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/psup_supervisor.sv
module psup_supervisor
    import psup_pkg::*;
#(
    parameter int unsigned RST_DLY     = 32000,
    parameter int unsigned UV_BLANK    = 6144,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             lockout_clr_i,
    input  logic [NRAIL-1:0] rail_good_i,
    input  logic [NRAIL-1:0] rail_ov_i,
    input  logic [NRAIL-1:0] rail_uv_i,
    output logic             rst_pull_low_o,
    output logic [NRAIL-1:0] conv_en_o,
    output logic             ls_force_o,
    output logic             ls_clamp_o
);
    localparam int unsigned RCW = $clog2(RST_DLY + 1);
    localparam int unsigned IW  = 2 + 3 * NRAIL;
    localparam logic [RCW-1:0] RLIM = RCW'(RST_DLY);

    typedef struct packed {
        fault_e         fault;
        logic [RCW-1:0] rcnt;
    } sup_st_t;

    // synchronized inputs
    logic [IW-1:0]    raw_in, syn_in;
    logic             en_s, lock_s;
    logic [NRAIL-1:0] good_s, ov_s, uv_s;
    logic [NRAIL-1:0] uv_armed;
    logic             conv_run;
    sup_st_t          st_d, st_q;

    assign raw_in = {en_i, lockout_clr_i, rail_good_i, rail_ov_i, rail_uv_i};

    psup_sync #(.W(IW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    assign {en_s, lock_s, good_s, ov_s, uv_s} = syn_in;

    assign conv_run = en_s && lock_s && (st_q.fault == FLT_NONE);

    // per-rail undervoltage blanking after converter start
    for (genvar r = 0; r < NRAIL; r++) begin : g_rail
        assign conv_en_o[r] = conv_run;
        psup_blank_timer #(.LIMIT(UV_BLANK)) u_blank (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (conv_en_o[r]),
            .done_o (uv_armed[r])
        );
    end

    always_comb begin
        st_d = st_q;
        if (!en_s) begin
            st_d.fault = FLT_NONE;
            st_d.rcnt  = '0;
        end else begin
            if (|ov_s)
                st_d.fault = FLT_OV;
            else if (st_q.fault == FLT_NONE && |(uv_s & uv_armed))
                st_d.fault = FLT_UV;

            if (lock_s && (&good_s) && st_d.fault == FLT_NONE) begin
                if (st_q.rcnt != RLIM) st_d.rcnt = st_q.rcnt + 1'b1;
            end else begin
                st_d.rcnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fault <= FLT_NONE;
            st_q.rcnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ls_force_o     = (st_q.fault == FLT_OV);
    assign ls_clamp_o     = (st_q.fault == FLT_UV);
    assign rst_pull_low_o = (st_q.fault != FLT_NONE) || (st_q.rcnt != RLIM);
endmodule

// File: rtl/psup_supervisor_chk.sv
module psup_supervisor_chk
    import psup_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en_s,
    input logic             lock_s,
    input logic [NRAIL-1:0] good_s,
    input logic [NRAIL-1:0] uv_armed,
    input logic             rst_pull_low_o,
    input logic [NRAIL-1:0] conv_en_o,
    input logic             ls_force_o,
    input logic             ls_clamp_o
);
    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pull_low_o) |-> ($past(good_s) == {NRAIL{1'b1}}) && $past(lock_s));

    assert_rail_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_pull_low_o && !(&good_s)) |=> rst_pull_low_o);

    assert_fault_effects_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_force_o || ls_clamp_o) |-> (rst_pull_low_o && conv_en_o == '0));

    assert_clamp_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_clamp_o) |-> ($past(uv_armed) != '0));

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ls_force_o && ls_clamp_o));

    assert_force_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_force_o && en_s) |=> ls_force_o);

    assert_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_s |-> (conv_en_o == '0));
endmodule

bind psup_supervisor psup_supervisor_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_s           (en_s),
    .lock_s         (lock_s),
    .good_s         (good_s),
    .uv_armed       (uv_armed),
    .rst_pull_low_o (rst_pull_low_o),
    .conv_en_o      (conv_en_o),
    .ls_force_o     (ls_force_o),
    .ls_clamp_o     (ls_clamp_o)
);

// File: tb/sim_psup_supervisor.sv
module sim_psup_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int D = 200;
    localparam int B = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic       lockout_clr_i = 1'b0;
    logic [1:0] rail_good_i = 2'b00;
    logic [1:0] rail_ov_i = 2'b00;
    logic [1:0] rail_uv_i = 2'b00;
    logic       rst_pull_low_o;
    logic [1:0] conv_en_o;
    logic       ls_force_o;
    logic       ls_clamp_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psup_supervisor #(.RST_DLY(D), .UV_BLANK(B), .SYNC_STAGES(2)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_i           (en_i),
        .lockout_clr_i  (lockout_clr_i),
        .rail_good_i    (rail_good_i),
        .rail_ov_i      (rail_ov_i),
        .rail_uv_i      (rail_uv_i),
        .rst_pull_low_o (rst_pull_low_o),
        .conv_en_o      (conv_en_o),
        .ls_force_o     (ls_force_o),
        .ls_clamp_o     (ls_clamp_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic lk, input logic [1:0] gd,
                         input logic [1:0] ov, input logic [1:0] uv);
        en_i = en; lockout_clr_i = lk; rail_good_i = gd; rail_ov_i = ov; rail_uv_i = uv;
    endtask

    task automatic t_reset();
        step(3);
        check("R1 rst_pull_low", int'(rst_pull_low_o), 1);
        check("R1 conv_en", int'(conv_en_o), 0);
        check("R1 force", int'(ls_force_o), 0);
        check("R1 clamp", int'(ls_clamp_o), 0);
        rst_n = 1'b1;
        step(2);
    endtask

    task automatic t_powerup();
        drive(1, 1, 2'b11, 2'b00, 2'b00);
        step(2);
        check("R2 conv_en on", int'(conv_en_o), 3);
        step(D - 1);
        check("R3 reset held at edge D+1", int'(rst_pull_low_o), 1);
        step(1);
        check("R3 reset released at edge D+2", int'(rst_pull_low_o), 0);
    endtask

    task automatic t_restart();
        drive(1, 1, 2'b10, 2'b00, 2'b00);
        step(3);
        check("R4 reset back after rail drop", int'(rst_pull_low_o), 1);
        drive(1, 1, 2'b11, 2'b00, 2'b00);
        step(100);
        drive(1, 1, 2'b01, 2'b00, 2'b00);
        step(1);
        drive(1, 1, 2'b11, 2'b00, 2'b00);
        step(D + 1);
        check("R4 count restarted, still held", int'(rst_pull_low_o), 1);
        step(1);
        check("R4 released after full recount", int'(rst_pull_low_o), 0);
    endtask

    task automatic t_ov();
        drive(1, 1, 2'b11, 2'b10, 2'b00);
        step(1);
        drive(1, 1, 2'b11, 2'b00, 2'b00);
        step(2);
        check("R5 force latched", int'(ls_force_o), 1);
        check("R5 conv off", int'(conv_en_o), 0);
        check("R5 reset asserted", int'(rst_pull_low_o), 1);
        step(D + 5);
        check("R5 force persists", int'(ls_force_o), 1);
        check("R9 no release while latched", int'(rst_pull_low_o), 1);
    endtask

    task automatic t_clear();
        drive(0, 1, 2'b11, 2'b00, 2'b00);
        step(3);
        check("R9 force cleared by enable low", int'(ls_force_o), 0);
        check("R9 clamp cleared", int'(ls_clamp_o), 0);
        check("R9 conv off while disabled", int'(conv_en_o), 0);
        check("R9 reset asserted while disabled", int'(rst_pull_low_o), 1);
    endtask

    task automatic t_uv_blank();
        drive(1, 1, 2'b11, 2'b00, 2'b10);
        step(2 + B);
        check("R6 uv ignored during blanking", int'(ls_clamp_o), 0);
        check("R6 conv still on at window end", int'(conv_en_o), 3);
        step(1);
        check("R7 clamp latched after blanking", int'(ls_clamp_o), 1);
        check("R7 conv off", int'(conv_en_o), 0);
        check("R7 reset asserted", int'(rst_pull_low_o), 1);
        drive(1, 1, 2'b11, 2'b00, 2'b00);
        step(5);
        check("R7 clamp persists", int'(ls_clamp_o), 1);
    endtask

    task automatic t_escalate();
        drive(1, 1, 2'b11, 2'b01, 2'b00);
        step(3);
        check("R8 ov overrides uv latch force", int'(ls_force_o), 1);
        check("R8 ov overrides uv latch clamp", int'(ls_clamp_o), 0);
        drive(1, 1, 2'b11, 2'b00, 2'b00);
        step(4);
        check("R8 force persists", int'(ls_force_o), 1);
    endtask

    task automatic t_simul();
        t_clear();
        drive(1, 1, 2'b11, 2'b00, 2'b00);
        step(B + 4);
        check("R2 conv on after re-enable", int'(conv_en_o), 3);
        drive(1, 1, 2'b11, 2'b01, 2'b10);
        step(3);
        check("R8 same-cycle force", int'(ls_force_o), 1);
        check("R8 same-cycle no clamp", int'(ls_clamp_o), 0);
    endtask

    task automatic t_lockout();
        t_clear();
        drive(1, 0, 2'b11, 2'b00, 2'b00);
        step(D + 5);
        check("R10 conv off under lockout", int'(conv_en_o), 0);
        check("R10 reset held under lockout", int'(rst_pull_low_o), 1);
        drive(1, 1, 2'b11, 2'b00, 2'b00);
        step(D + 1);
        check("R10 held until full count", int'(rst_pull_low_o), 1);
        step(1);
        check("R10 released after lockout clear", int'(rst_pull_low_o), 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_restart();
        t_ov();
        t_clear();
        t_uv_blank();
        t_escalate();
        t_simul();
        t_lockout();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule